// File: doc/BRIEF.md
# Calendar alarm match controller

This block watches the running time of day and calendar date, supplied in BCD by an external real-time counter, and raises a sticky alarm flag when the fields chosen by four mask bits match four programmable alarm bytes. The comparison runs once per one-second strobe. The time inputs must already show the new second in the cycle the strobe is high. The controller holds no time of its own. It needs only its clock, so it keeps working from a backup supply and can serve as a wake-up source.

Software sets up the alarm through a small synchronous register port. Each alarm byte carries a mask bit in bit 7. The day/date byte also carries a select bit in bit 6 that picks between day-of-week and date-of-month. A control register holds two enables: one for the interrupt pin and one for the power-request pin. Both pins are active-low, modelled as logic outputs that are 0 when asserted. Reading the flags register returns the alarm flag and clears it.

Register offsets, in this order: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 alarm day/date, 4 control (bit 0 interrupt enable, bit 1 power enable), 5 flags (bit 0 alarm flag). In the mask code below, K1 is bit 7 of offset 0, K2 of offset 1, K3 of offset 2 and K4 of offset 3.

Top module: `tod_alarm_ctrl`

## Requirements
- R1: After reset the alarm flag is 0, irq_n and pwr_n are 1, and all registers read 0.
- R2: A read with reg_re high returns its data on reg_rdata in the next cycle. Offsets 0..3 read back the full written byte. Offset 4 reads back only bits 1:0. Offset 5 reads the flag in bit 0. Offsets 6 and 7 read 0, and writes to them are ignored.
- R3: With K4..K1 = 1111 the flag sets on every strobe, whatever the time.
- R4: With K4..K1 = 1110 the flag sets when seconds bits 6:0 equal alarm seconds bits 6:0.
- R5: With K4..K1 = 1100 the flag sets when both minutes and seconds match.
- R6: With K4..K1 = 1000 the flag sets when hours (bits 5:0), minutes and seconds all match.
- R7: With K4..K1 = 0000 hours, minutes and seconds must match. If select bit 6 of offset 3 is 0, date bits 5:0 must also match. If it is 1, day-of-week bits 2:0 must match instead.
- R8: Any other mask code makes the flag set on every strobe.
- R9: The flag is never set in a cycle without a strobe, even when the time fields match.
- R10: The flag stays set until a read of offset 5, which returns 1 and clears it. If a strobe match comes in the same cycle as that read, the read returns the old value and the flag ends set.
- R11: irq_n is 0 exactly when the flag and the interrupt enable are both 1. pwr_n is 0 exactly when the flag and the power enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second strobe; time inputs valid in the same cycle |
| t_sec | input | 8 | BCD seconds |
| t_min | input | 8 | BCD minutes |
| t_hour | input | 8 | BCD hours, 24-hour |
| t_dow | input | 8 | Day of week, 1..7 |
| t_date | input | 8 | BCD date of month |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after reg_re |
| irq_n | output | 1 | Active-low interrupt request |
| pwr_n | output | 1 | Active-low power-on request |

## Verification
The bench covers each mask code with one time that differs in exactly the field the code should still compare, then with a time that matches. A decoder that dropped a field would fire early, and one that compared a masked field would never fire. Day-of-week and date are each set to values that match only the unselected field, which exposes an inverted select bit. Two illegal mask codes must fire on a non-matching time. A read of the flag that lands in the same cycle as a matching strobe must return 0 and leave the flag set; a design that let the clear win would lose that alarm.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned N_ALM  = 4;

    typedef enum logic [2:0] {
        RATE_EVERY,
        RATE_S,
        RATE_MS,
        RATE_HMS,
        RATE_DATE,
        RATE_DOW
    } rate_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dd;
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] mn;
        logic [BYTE_W-1:0] sc;
    } alarm_cfg_t;

    // mask is {K4,K3,K2,K1}; unlisted codes fall back to every second
    function automatic rate_e decode_rate(input logic [3:0] mask, input logic sel_dow);
        rate_e r;
        case (mask)
            4'b1111: r = RATE_EVERY;
            4'b1110: r = RATE_S;
            4'b1100: r = RATE_MS;
            4'b1000: r = RATE_HMS;
            4'b0000: r = sel_dow ? RATE_DOW : RATE_DATE;
            default: r = RATE_EVERY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import tod_alarm_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tdf,
    output alarm_cfg_t        cfg,
    output logic              tie,
    output logic              tpe,
    output logic              flag_rd,
    output logic [BYTE_W-1:0] rdata
);
    localparam logic [AW-1:0] OFS_CTRL = AW'(N_ALM);
    localparam logic [AW-1:0] OFS_FLAG = AW'(N_ALM + 1);

    typedef struct packed {
        logic [N_ALM-1:0][BYTE_W-1:0] alm;
        logic [1:0]                   ctrl;
        logic [BYTE_W-1:0]            rdata;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int i = 0; i < N_ALM; i++) begin
                if (addr == AW'(i)) st_d.alm[i] = wdata;
            end
            if (addr == OFS_CTRL) st_d.ctrl = wdata[1:0];
        end
        if (re) begin
            st_d.rdata = '0;
            for (int i = 0; i < N_ALM; i++) begin
                if (addr == AW'(i)) st_d.rdata = st_q.alm[i];
            end
            if (addr == OFS_CTRL) st_d.rdata = {{(BYTE_W-2){1'b0}}, st_q.ctrl};
            if (addr == OFS_FLAG) st_d.rdata = {{(BYTE_W-1){1'b0}}, tdf};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = alarm_cfg_t'(st_q.alm);
    assign tie     = st_q.ctrl[0];
    assign tpe     = st_q.ctrl[1];
    assign flag_rd = re && (addr == OFS_FLAG);
    assign rdata   = st_q.rdata;
endmodule

// File: rtl/alm_cmp.sv
module alm_cmp
    import tod_alarm_pkg::*;
(
    input  alarm_cfg_t        cfg,
    input  logic [BYTE_W-1:0] t_sec,
    input  logic [BYTE_W-1:0] t_min,
    input  logic [BYTE_W-1:0] t_hour,
    input  logic [BYTE_W-1:0] t_dow,
    input  logic [BYTE_W-1:0] t_date,
    output rate_e             rate,
    output logic              hit
);
    logic s_eq, m_eq, h_eq, dt_eq, dw_eq;

    always_comb begin
        s_eq  = t_sec[6:0]  == cfg.sc[6:0];
        m_eq  = t_min[6:0]  == cfg.mn[6:0];
        h_eq  = t_hour[5:0] == cfg.hr[5:0];
        dt_eq = t_date[5:0] == cfg.dd[5:0];
        dw_eq = t_dow[2:0]  == cfg.dd[2:0];
        rate  = decode_rate({cfg.dd[7], cfg.hr[7], cfg.mn[7], cfg.sc[7]}, cfg.dd[6]);
        case (rate)
            RATE_S:    hit = s_eq;
            RATE_MS:   hit = s_eq && m_eq;
            RATE_HMS:  hit = s_eq && m_eq && h_eq;
            RATE_DATE: hit = s_eq && m_eq && h_eq && dt_eq;
            RATE_DOW:  hit = s_eq && m_eq && h_eq && dw_eq;
            default:   hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
    import tod_alarm_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [7:0]        t_sec,
    input  logic [7:0]        t_min,
    input  logic [7:0]        t_hour,
    input  logic [7:0]        t_dow,
    input  logic [7:0]        t_date,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [AW-1:0]     reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_n,
    output logic              pwr_n
);
    typedef struct packed {
        logic tdf;
    } flag_t;

    flag_t      fl_d, fl_q;
    alarm_cfg_t cfg;
    rate_e      rate;
    logic       hit, tie, tpe, flag_rd, tdf;

    alm_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .re      (reg_re),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .tdf     (tdf),
        .cfg     (cfg),
        .tie     (tie),
        .tpe     (tpe),
        .flag_rd (flag_rd),
        .rdata   (reg_rdata)
    );

    alm_cmp u_cmp (
        .cfg    (cfg),
        .t_sec  (t_sec),
        .t_min  (t_min),
        .t_hour (t_hour),
        .t_dow  (t_dow),
        .t_date (t_date),
        .rate   (rate),
        .hit    (hit)
    );

    // a strobe match outranks a clearing read in the same cycle
    always_comb begin
        fl_d = fl_q;
        if (flag_rd)     fl_d.tdf = 1'b0;
        if (tick && hit) fl_d.tdf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign tdf   = fl_q.tdf;
    assign irq_n = !(tdf && tie);
    assign pwr_n = !(tdf && tpe);
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk
    import tod_alarm_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          reg_re,
    input logic [AW-1:0] reg_addr,
    input logic          hit,
    input rate_e         rate,
    input logic          tdf,
    input logic          tie,
    input logic          irq_n,
    input logic          pwr_n
);
    localparam logic [AW-1:0] OFS_FLAG = AW'(N_ALM + 1);

    AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(tdf) |-> $past(tick)); // R9
    AST_EVERY_FIRES: assert property (@(posedge clk) disable iff (!rst_n) (tick && rate == RATE_EVERY) |=> tdf); // R8
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n) (tick && hit) |=> tdf); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tdf && !(reg_re && reg_addr == OFS_FLAG)) |=> tdf); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (reg_re && reg_addr == OFS_FLAG && !tick) |=> (!tdf && irq_n && pwr_n)); // R10
    AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !tdf |-> (irq_n && pwr_n)); // R11
    AST_IRQ_NEEDS_TIE: assert property (@(posedge clk) disable iff (!rst_n) !irq_n |-> tie); // R11
endmodule

bind tod_alarm_ctrl tod_alarm_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .hit      (hit),
    .rate     (rate),
    .tdf      (tdf),
    .tie      (tie),
    .irq_n    (irq_n),
    .pwr_n    (pwr_n)
);

// File: tb/sim_tod_alarm_ctrl.sv
`timescale 1ns/1ps
module sim_tod_alarm_ctrl;
    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [7:0] t_sec = 0, t_min = 0, t_hour = 0, t_dow = 1, t_date = 1;
    logic       reg_we = 0, reg_re = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       irq_n, pwr_n;

    always #2.5 clk = ~clk;

    tod_alarm_ctrl #(.AW(3)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .t_sec(t_sec), .t_min(t_min),
        .t_hour(t_hour), .t_dow(t_dow), .t_date(t_date), .reg_we(reg_we),
        .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n), .pwr_n(pwr_n)
    );

    typedef struct { bit pins; logic [7:0] exp; string tag; } item_t;
    item_t q[$];
    event  chk_ev;
    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;

    // monitor: pops expectations and compares against the ports
    initial forever begin
        @(chk_ev);
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.pins ? {6'b0, irq_n, pwr_n} : reg_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(input bit pins, input logic [7:0] exp, input string tag);
        item_t it;
        it.pins = pins; it.exp = exp; it.tag = tag;
        q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); reg_re = 1; reg_addr = a;
        @(negedge clk); reg_re = 0;
        push(0, exp, tag);
    endtask

    // expected pins as {irq_n, pwr_n}
    task automatic pins(input logic [1:0] exp, input string tag);
        @(negedge clk);
        push(1, {6'b0, exp}, tag);
    endtask

    task automatic stamp(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] dw, input logic [7:0] dt);
        @(negedge clk);
        t_hour = h; t_min = m; t_sec = s; t_dow = dw; t_date = dt; tick = 1;
        @(negedge clk); tick = 0;
    endtask

    task automatic alarm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h, input logic [7:0] dd);
        wr(0, s); wr(1, m); wr(2, h); wr(3, dd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        pins(2'b11, "R1 pins idle after reset");
        rd(0, 8'h00, "R1 alarm seconds reset");
        rd(4, 8'h00, "R1 control reset");
        rd(5, 8'h00, "R1 flag reset");

        alarm(8'h59, 8'hA4, 8'h3C, 8'h65);
        rd(0, 8'h59, "R2 readback 0"); rd(1, 8'hA4, "R2 readback 1");
        rd(2, 8'h3C, "R2 readback 2"); rd(3, 8'h65, "R2 readback 3");
        wr(4, 8'hFF); rd(4, 8'h03, "R2 control keeps two bits");
        wr(6, 8'h77); rd(6, 8'h00, "R2 unused offset reads 0");

        wr(4, 8'h01);
        alarm(8'h80, 8'h80, 8'h80, 8'h80);
        stamp(8'h12, 8'h34, 8'h56, 3, 8'h09);
        pins(2'b01, "R11 irq low with tie, pwr high");
        rd(5, 8'h01, "R3 every second sets flag");
        pins(2'b11, "R10 pins release after read");
        rd(5, 8'h00, "R10 read cleared flag");
        stamp(8'h00, 8'h00, 8'h01, 1, 8'h01);
        rd(5, 8'h01, "R3 fires on next strobe too");

        t_sec = 8'h01; repeat (4) @(negedge clk);
        rd(5, 8'h00, "R9 no strobe no set");

        alarm(8'h30, 8'h80, 8'h80, 8'h80);
        stamp(8'h05, 8'h30, 8'h29, 2, 8'h11);
        rd(5, 8'h00, "R4 seconds differ");
        stamp(8'h07, 8'h11, 8'h30, 2, 8'h11);
        rd(5, 8'h01, "R4 seconds match");

        alarm(8'h15, 8'h42, 8'h80, 8'h80);
        stamp(8'h01, 8'h41, 8'h15, 2, 8'h11);
        rd(5, 8'h00, "R5 minutes differ");
        stamp(8'h09, 8'h42, 8'h15, 6, 8'h28);
        rd(5, 8'h01, "R5 minutes and seconds match");

        alarm(8'h05, 8'h10, 8'h23, 8'h80);
        stamp(8'h22, 8'h10, 8'h05, 2, 8'h11);
        rd(5, 8'h00, "R6 hours differ");
        stamp(8'h23, 8'h10, 8'h05, 4, 8'h30);
        rd(5, 8'h01, "R6 full time match");

        alarm(8'h05, 8'h10, 8'h23, 8'h17);
        stamp(8'h23, 8'h10, 8'h05, 5, 8'h17);
        rd(5, 8'h01, "R7 date match");
        stamp(8'h23, 8'h10, 8'h05, 7, 8'h16);
        rd(5, 8'h00, "R7 date differs");
        wr(3, 8'h45);
        stamp(8'h23, 8'h10, 8'h05, 5, 8'h16);
        rd(5, 8'h01, "R7 day-of-week match");
        stamp(8'h23, 8'h10, 8'h05, 4, 8'h05);
        rd(5, 8'h00, "R7 day differs, date equals code");

        alarm(8'h80, 8'h00, 8'h00, 8'h00);
        stamp(8'h02, 8'h03, 8'h04, 1, 8'h02);
        rd(5, 8'h01, "R8 illegal code 0001 fires");
        alarm(8'h00, 8'h80, 8'h00, 8'h00);
        stamp(8'h02, 8'h03, 8'h04, 1, 8'h02);
        rd(5, 8'h01, "R8 illegal code 0010 fires");

        alarm(8'h80, 8'h80, 8'h80, 8'h80);
        @(negedge clk);
        tick = 1; reg_re = 1; reg_addr = 5;
        @(negedge clk); tick = 0; reg_re = 0;
        push(0, 8'h00, "R10 same-cycle read returns old");
        rd(5, 8'h01, "R10 strobe wins over clear");

        wr(4, 8'h02);
        stamp(8'h00, 8'h00, 8'h00, 1, 8'h01);
        pins(2'b10, "R11 pwr low with tpe, irq high");
        rd(5, 8'h01, "R10 flag held");
        pins(2'b11, "R11 both released");

        done = 1;
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule